// File: doc/BRIEF.md
# CAN Message Object Transmit Scheduler

This block keeps the transmit status of a bank of message objects and decides which object the frame transmitter sends next. Each object carries four status bits: a transmit request, a new-data flag, a transmit-interrupt enable and an interrupt-pending flag. A host port writes any subset of these bits of one object per cycle under a bit mask. Whenever the scheduler is idle, it picks the pending object with the lowest index and hands its index to the transmitter with a one-cycle start strobe after a single preparation cycle. It then waits for the transmitter to report success, error or arbitration loss.

Two retry policies are selected by a mode input. In retry mode a failed frame stays pending and is arbitrated again. In single-shot mode any finished frame drops its request, and a failed frame leaves new-data and interrupt-pending untouched so that the host can tell it was not sent. Any number of objects requested together are all served in priority order. If a request is withdrawn during the preparation cycle, the frame is dropped cleanly and the object is scheduled again as soon as it is re-requested. If the host writes fresh content into the object that is on the wire, that content survives the completion of the old frame and is sent next.

Top module: `can_tx_sched`

## Requirements
- R1: After reset every status bit of every object is 0, tx_start_o is 0 and the scheduler is idle.
- R2: When idle, the scheduler selects the pending object with the lowest index. Requests that arrive while a frame is in flight are served afterwards in ascending index order.
- R3: tx_start_o is high for exactly one cycle per frame. tx_idx_o stays unchanged from the strobe until the cycle in which tx_done_i is accepted.
- R4: tx_result_i is decoded as 01 success, 10 error and 11 arbitration loss, with 00 treated as error. On success the request (bit 0) and new-data (bit 1) of the sent object are cleared.
- R5: On success, interrupt-pending (bit 3) is set only if transmit-interrupt enable (bit 2) of that object is 1.
- R6: With dar_i = 0, an error or arbitration loss leaves all four bits of the object unchanged, and the object is started again.
- R7: With dar_i = 1, an error or arbitration loss clears the request and leaves new-data and interrupt-pending unchanged.
- R8: With dar_i = 1, all objects requested together are each started once, in ascending index order, with no limit on their number.
- R9: Clearing the request of the selected object so that it is 0 at the end of the preparation cycle produces no start, and the scheduler returns to idle. Setting the request again leads to a start of that object.
- R10: A host write that sets the request of the object in flight keeps request and new-data set through completion of that frame, and the object is started again.
- R11: A host write changes, one cycle later, exactly the bits selected by host_mask_i of object host_idx_i, to host_data_i. The bit positions are request 0, new-data 1, enable 2 and pending 3. The host write takes precedence over a completion in the same cycle.
- R12: tx_done_i is ignored while no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dar_i | input | 1 | 1: single-shot mode, 0: retry mode |
| host_we_i | input | 1 | Host status write strobe |
| host_idx_i | input | IDX_W | Object addressed by the host write |
| host_mask_i | input | 4 | Bits to write (0 rqst, 1 newdat, 2 txie, 3 intpnd) |
| host_data_i | input | 4 | Values for the masked bits |
| tx_done_i | input | 1 | Transmitter finished the current frame |
| tx_result_i | input | 2 | Frame outcome, valid with tx_done_i |
| tx_start_o | output | 1 | One-cycle start strobe to the transmitter |
| tx_idx_o | output | IDX_W | Index of the object being sent |
| rqst_o | output | NUM_OBJ | Transmit-request bits |
| newdat_o | output | NUM_OBJ | New-data bits |
| txie_o | output | NUM_OBJ | Transmit-interrupt-enable bits |
| intpnd_o | output | NUM_OBJ | Interrupt-pending bits |

## Verification
The bench builds the block with the default of 32 objects, so the lowest-priority object 31 and objects across the whole index range take part in arbitration. With the full bank, a backlog of five concurrent single-shot requests is more than two objects deep, and high-index requests are queued behind a long frame. The transmitter model in the bench has a latency that can be set, which reaches the preparation-cycle withdrawal and the rewrite of an object that is on the wire.

// File: rtl/can_sched_pkg.sv
package can_sched_pkg;
  localparam int unsigned F_RQST   = 0;
  localparam int unsigned F_NEWDAT = 1;
  localparam int unsigned F_TXIE   = 2;
  localparam int unsigned F_INTPND = 3;
  localparam int unsigned NFIELD   = 4;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_OK   = 2'b01,
    RES_ERR  = 2'b10,
    RES_ARB  = 2'b11
  } tx_res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_BUSY = 2'd2
  } sch_state_e;
endpackage

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic [NUM_OBJ-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/can_obj_bank.sv
module can_obj_bank
  import can_sched_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [IDX_W-1:0]   host_idx_i,
  input  logic [NFIELD-1:0]  host_mask_i,
  input  logic [NFIELD-1:0]  host_data_i,
  input  logic               upd_en_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic               upd_clr_rq_i,
  input  logic               upd_clr_nd_i,
  input  logic               upd_set_ip_i,
  output logic [NUM_OBJ-1:0] rqst_o,
  output logic [NUM_OBJ-1:0] newdat_o,
  output logic [NUM_OBJ-1:0] txie_o,
  output logic [NUM_OBJ-1:0] intpnd_o
);
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic [NFIELD-1:0] st_q, st_d;

    always_comb begin
      st_d = st_q;
      if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        if (upd_clr_rq_i) st_d[F_RQST] = 1'b0;
        if (upd_clr_nd_i) st_d[F_NEWDAT] = 1'b0;
        if (upd_set_ip_i && st_q[F_TXIE]) st_d[F_INTPND] = 1'b1;
      end
      // host write wins over a same-cycle completion
      if (host_we_i && host_idx_i == IDX_W'(g))
        st_d = (st_d & ~host_mask_i) | (host_data_i & host_mask_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= st_d;
    end

    assign rqst_o[g]   = st_q[F_RQST];
    assign newdat_o[g] = st_q[F_NEWDAT];
    assign txie_o[g]   = st_q[F_TXIE];
    assign intpnd_o[g] = st_q[F_INTPND];
  end
endmodule

// File: rtl/can_tx_fsm.sv
module can_tx_fsm
  import can_sched_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dar_i,
  input  logic               any_i,
  input  logic [IDX_W-1:0]   pick_i,
  input  logic [NUM_OBJ-1:0] rqst_i,
  input  logic               host_we_i,
  input  logic [IDX_W-1:0]   host_idx_i,
  input  logic [NFIELD-1:0]  host_mask_i,
  input  logic [NFIELD-1:0]  host_data_i,
  input  logic               tx_done_i,
  input  logic [1:0]         tx_result_i,
  output logic               tx_start_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic               upd_en_o,
  output logic               upd_clr_rq_o,
  output logic               upd_clr_nd_o,
  output logic               upd_set_ip_o,
  output logic               busy_o,
  output logic               rewr_o
);
  sch_state_e       state_q, state_d;
  logic [IDX_W-1:0] sel_q;
  logic             start_q, rewr_q;
  logic             done_ev, ok, host_rewr;

  assign done_ev   = (state_q == ST_BUSY) && tx_done_i;
  assign ok        = (tx_res_e'(tx_result_i) == RES_OK);
  assign host_rewr = host_we_i && host_idx_i == sel_q &&
                     host_mask_i[F_RQST] && host_data_i[F_RQST];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (any_i) state_d = ST_PREP;
      ST_PREP: state_d = rqst_i[sel_q] ? ST_BUSY : ST_IDLE;
      ST_BUSY: if (tx_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      start_q <= 1'b0;
      rewr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == ST_PREP) && rqst_i[sel_q];
      if (state_q == ST_IDLE && any_i) sel_q <= pick_i;
      if (state_q == ST_PREP)          rewr_q <= 1'b0;
      else if (state_q == ST_BUSY && host_rewr) rewr_q <= 1'b1;
    end
  end

  assign tx_start_o   = start_q;
  assign sel_o        = sel_q;
  assign upd_en_o     = done_ev;
  assign upd_clr_rq_o = !rewr_q && (ok || dar_i);
  assign upd_clr_nd_o = !rewr_q && ok;
  assign upd_set_ip_o = ok;
  assign busy_o       = (state_q == ST_BUSY);
  assign rewr_o       = rewr_q;
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_sched_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dar_i,
  input  logic               host_we_i,
  input  logic [IDX_W-1:0]   host_idx_i,
  input  logic [3:0]         host_mask_i,
  input  logic [3:0]         host_data_i,
  input  logic               tx_done_i,
  input  logic [1:0]         tx_result_i,
  output logic               tx_start_o,
  output logic [IDX_W-1:0]   tx_idx_o,
  output logic [NUM_OBJ-1:0] rqst_o,
  output logic [NUM_OBJ-1:0] newdat_o,
  output logic [NUM_OBJ-1:0] txie_o,
  output logic [NUM_OBJ-1:0] intpnd_o
);
  logic             any_w, upd_en_w, clr_rq_w, clr_nd_w, set_ip_w, busy_w, rewr_w;
  logic [IDX_W-1:0] pick_w, sel_w;

  can_prio_pick #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_pick (
    .req_i (rqst_o),
    .any_o (any_w),
    .idx_o (pick_w)
  );

  can_tx_fsm #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dar_i        (dar_i),
    .any_i        (any_w),
    .pick_i       (pick_w),
    .rqst_i       (rqst_o),
    .host_we_i    (host_we_i),
    .host_idx_i   (host_idx_i),
    .host_mask_i  (host_mask_i),
    .host_data_i  (host_data_i),
    .tx_done_i    (tx_done_i),
    .tx_result_i  (tx_result_i),
    .tx_start_o   (tx_start_o),
    .sel_o        (sel_w),
    .upd_en_o     (upd_en_w),
    .upd_clr_rq_o (clr_rq_w),
    .upd_clr_nd_o (clr_nd_w),
    .upd_set_ip_o (set_ip_w),
    .busy_o       (busy_w),
    .rewr_o       (rewr_w)
  );

  can_obj_bank #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_idx_i   (host_idx_i),
    .host_mask_i  (host_mask_i),
    .host_data_i  (host_data_i),
    .upd_en_i     (upd_en_w),
    .upd_idx_i    (sel_w),
    .upd_clr_rq_i (clr_rq_w),
    .upd_clr_nd_i (clr_nd_w),
    .upd_set_ip_i (set_ip_w),
    .rqst_o       (rqst_o),
    .newdat_o     (newdat_o),
    .txie_o       (txie_o),
    .intpnd_o     (intpnd_o)
  );

  assign tx_idx_o = sel_w;
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned IDX_W   = $clog2(NUM_OBJ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dar_i,
  input logic               host_we_i,
  input logic               busy_i,
  input logic               rewr_i,
  input logic               tx_done_i,
  input logic [1:0]         tx_result_i,
  input logic               tx_start_i,
  input logic [IDX_W-1:0]   tx_idx_i,
  input logic [NUM_OBJ-1:0] rqst_i,
  input logic [NUM_OBJ-1:0] newdat_i,
  input logic [NUM_OBJ-1:0] txie_i,
  input logic [NUM_OBJ-1:0] intpnd_i
);
  logic fin, fin_ok;
  assign fin    = busy_i && tx_done_i && !host_we_i;
  assign fin_ok = fin && tx_result_i == 2'b01;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !tx_start_i); // R3
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tx_done_i) |=> $stable(tx_idx_i)); // R3
  AST_OK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_ok && !rewr_i) |=> (!rqst_i[$past(tx_idx_i)] && !newdat_i[$past(tx_idx_i)])); // R4
  AST_OK_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_ok |=> (intpnd_i[$past(tx_idx_i)] == ($past(txie_i[tx_idx_i]) || $past(intpnd_i[tx_idx_i])))); // R5
  AST_RETRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !fin_ok && !dar_i) |=> rqst_i[$past(tx_idx_i)]); // R6
  AST_SHOT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !fin_ok && dar_i && !rewr_i) |=>
      (!rqst_i[$past(tx_idx_i)] && newdat_i[$past(tx_idx_i)] == $past(newdat_i[tx_idx_i]))); // R7
  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && tx_done_i && !host_we_i && !tx_start_i) |=> $stable(rqst_i)); // R12
endmodule

bind can_tx_sched can_tx_sched_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dar_i       (dar_i),
  .host_we_i   (host_we_i),
  .busy_i      (busy_w),
  .rewr_i      (rewr_w),
  .tx_done_i   (tx_done_i),
  .tx_result_i (tx_result_i),
  .tx_start_i  (tx_start_o),
  .tx_idx_i    (tx_idx_o),
  .rqst_i      (rqst_o),
  .newdat_i    (newdat_o),
  .txie_i      (txie_o),
  .intpnd_i    (intpnd_o)
);

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb;
  localparam int N = 32;
  localparam int IW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, dar = 0, we = 0, done = 0;
  logic [IW-1:0] hidx = '0;
  logic [3:0] hmask = '0, hdata = '0;
  logic [1:0] res = 2'b00;
  logic tx_start;
  logic [IW-1:0] tx_idx;
  logic [N-1:0] rq, nd, ie, ip;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_sched #(.NUM_OBJ(N), .IDX_W(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dar_i(dar), .host_we_i(we), .host_idx_i(hidx),
    .host_mask_i(hmask), .host_data_i(hdata), .tx_done_i(done), .tx_result_i(res),
    .tx_start_o(tx_start), .tx_idx_o(tx_idx), .rqst_o(rq), .newdat_o(nd),
    .txie_o(ie), .intpnd_o(ip)
  );

  task automatic chk(input bit c, input string t, input longint act, input longint exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // behavioural reference
  logic [3:0] m_b [N];
  int m_state, m_sel, m_pick;
  bit m_start, m_rewr;
  logic [3:0] nb [N];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_b[i]) m_b[i] = 4'h0;
      m_state = 0; m_sel = 0; m_start = 0; m_rewr = 0;
    end else begin
      nb = m_b;
      m_pick = -1;
      for (int i = N - 1; i >= 0; i--) if (m_b[i][0]) m_pick = i;
      case (m_state)
        0: begin m_start = 0; if (m_pick >= 0) begin m_sel = m_pick; m_state = 1; end end
        1: if (m_b[m_sel][0]) begin m_state = 2; m_start = 1; m_rewr = 0; end
           else begin m_state = 0; m_start = 0; end
        default: begin
          m_start = 0;
          if (done) begin
            if (res == 2'b01) begin
              if (!m_rewr) begin nb[m_sel][0] = 0; nb[m_sel][1] = 0; end
              if (m_b[m_sel][2]) nb[m_sel][3] = 1;
            end else if (dar && !m_rewr) nb[m_sel][0] = 0;
            m_state = 0;
          end
          if (we && int'(hidx) == m_sel && hmask[0] && hdata[0]) m_rewr = 1;
        end
      endcase
      if (we) nb[hidx] = (nb[hidx] & ~hmask) | (hdata & hmask);
      m_b = nb;
    end
  end

  function automatic logic [N-1:0] mvec(input int f);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_b[i][f];
    return v;
  endfunction

  // compare every cycle
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      chk(rq == mvec(0) && nd == mvec(1) && ie == mvec(2) && ip == mvec(3),
          {tag, " status bits"}, {rq, nd}, {mvec(0), mvec(1)});
      chk(tx_start == m_start, {tag, " start"}, tx_start, m_start);
      if (m_state == 2) chk(int'(tx_idx) == m_sel, {tag, " idx"}, tx_idx, m_sel);
    end
  end

  // transmitter model
  int rsp_lat = 2, rsp_cnt = 0;
  logic [1:0] res_q [$];
  int log_q [$];
  bit spur = 0;
  initial forever begin
    @(negedge clk);
    done = 0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        done = 1;
        res = (res_q.size() > 0) ? res_q.pop_front() : 2'b01;
      end
    end else if (tx_start) begin
      log_q.push_back(int'(tx_idx));
      rsp_cnt = rsp_lat;
    end
    if (spur) begin done = 1; res = 2'b10; spur = 0; end
  end

  task automatic hw(input int idx, input logic [3:0] m, input logic [3:0] d);
    @(negedge clk); we = 1; hidx = IW'(idx); hmask = m; hdata = d;
  endtask
  task automatic hw_off();
    @(negedge clk); we = 0;
  endtask
  task automatic quiet();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (m_state == 0 && mvec(0) == '0 && rsp_cnt == 0 && !done) break;
    end
    repeat (3) @(negedge clk);
  endtask
  task automatic wait_starts(input int n);
    for (int k = 0; k < 3000 && log_q.size() < n; k++) @(negedge clk);
  endtask
  task automatic chk_log(input string t, input int exp [$]);
    chk(log_q.size() == exp.size(), {t, " start count"}, log_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp[i], {t, " start order"}, log_q[i], exp[i]);
    log_q.delete();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] s_rq, s_ip;
    repeat (3) @(negedge clk);
    chk(rq == 0 && nd == 0 && ie == 0 && ip == 0, "R1 status at reset", rq | ip, 0);
    chk(tx_start == 0, "R1 no start at reset", tx_start, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R4 R5: backlog behind a long frame on object 30
    tag = "R2";
    hw(3, 4'h4, 4'h4); hw(7, 4'h4, 4'h4); hw_off();
    rsp_lat = 30;
    hw(30, 4'h3, 4'h3); hw_off();
    wait_starts(1);
    rsp_lat = 2;
    hw(20, 4'h3, 4'h3); hw(7, 4'h3, 4'h3); hw(3, 4'h3, 4'h3); hw_off();
    quiet();
    chk_log("R2", '{30, 3, 7, 20});
    chk(rq == 0 && nd == 0, "R4 rqst/newdat cleared", {rq, nd}, 0);
    chk(ip == ((N'(1) << 3) | (N'(1) << 7)), "R5 intpnd only where enabled", ip, (1 << 3) | (1 << 7));

    // R6 retry mode
    tag = "R6";
    res_q = '{2'b10, 2'b11, 2'b01};
    hw(5, 4'h3, 4'h3); hw_off();
    quiet();
    chk_log("R6", '{5, 5, 5});
    chk(rq[5] == 0, "R6 cleared after final success", rq[5], 0);

    // R7 single-shot failure
    tag = "R7"; dar = 1;
    res_q = '{2'b10};
    hw(9, 4'h7, 4'h7); hw_off();
    quiet();
    chk_log("R7", '{9});
    chk(rq[9] == 0 && nd[9] == 1 && ip[9] == 0, "R7 drop keeps newdat", {rq[9], nd[9], ip[9]}, 3'b010);

    // R8 single-shot backlog deeper than two
    tag = "R8";
    rsp_lat = 25;
    hw(31, 4'h3, 4'h3); hw_off();
    wait_starts(1);
    rsp_lat = 2;
    hw(12, 4'h3, 4'h3); hw(2, 4'h3, 4'h3); hw(8, 4'h3, 4'h3); hw(4, 4'h3, 4'h3);
    hw(6, 4'h3, 4'h3); hw_off();
    quiet();
    chk_log("R8", '{31, 2, 4, 6, 8, 12});
    chk(rq == 0, "R8 all served", rq, 0);
    dar = 0;

    // R9 withdrawal in preparation cycle
    tag = "R9";
    hw(15, 4'h1, 4'h1); hw(15, 4'h1, 4'h0); hw_off();
    repeat (5) @(negedge clk);
    chk(log_q.size() == 0, "R9 no start after withdrawal", log_q.size(), 0);
    hw(15, 4'h1, 4'h1); hw_off();
    quiet();
    chk_log("R9", '{15});

    // R10 rewrite of object in flight
    tag = "R10";
    rsp_lat = 20;
    hw(22, 4'h3, 4'h3); hw_off();
    wait_starts(1);
    rsp_lat = 2;
    hw(22, 4'h3, 4'h3); hw_off();
    for (int k = 0; k < 40 && m_state != 0; k++) @(negedge clk);
    @(negedge clk);
    chk(rq[22] == 1 && nd[22] == 1, "R10 new content kept", {rq[22], nd[22]}, 2'b11);
    quiet();
    chk_log("R10", '{22, 22});

    // R11 masked writes
    tag = "R11";
    hw(0, 4'h4, 4'hF); hw_off();
    chk(ie[0] == 1 && rq[0] == 0 && nd[0] == 0 && ip[0] == 0, "R11 only masked bit", {rq[0], nd[0], ie[0], ip[0]}, 4'b0010);
    hw(3, 4'h8, 4'h0); hw_off();
    chk(ip[3] == 0 && ip[7] == 1 && ie[3] == 1, "R11 intpnd clear", {ip[3], ip[7]}, 2'b01);

    // R12 stray done while idle
    tag = "R12";
    hw(11, 4'h2, 4'h2); hw_off();
    s_rq = rq; s_ip = ip;
    spur = 1;
    repeat (4) @(negedge clk);
    chk(rq == s_rq && ip == s_ip && log_q.size() == 0, "R12 idle done ignored", rq, s_rq);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule